// File: doc/BRIEF.md
# Group Interrupt Flag Bank

This block keeps the event status of one transfer group in a digital input/output acquisition engine. Four event sources give one-cycle pulses (count done, wait fault, primary terminal count, secondary terminal count). Each pulse sets a sticky flag that stays set until software clears it. A fifth flag, transfer-ready, is not sticky: it follows a data-available level, one cycle late, so it reads as set for as long as data remains. An enable register with the same bit layout as the flags selects which flags may raise the interrupt. A master control register opens the interrupt output and chooses which of four interrupt lines it is routed to.

Software reaches the bank over a byte-wide register bus. Writes complete in one cycle and reads are combinational. Flags are not cleared in place. A primary clear register clears the wait and terminal-count flags, and the same write can issue one-cycle reset strobes toward the FIFO and the DMA engine. Count-done has its own secondary clear register. When an event pulse and a clear of the same flag land in the same cycle, the event wins.

Top module: `grp_irq_flag_bank`

## Requirements
- R1: After reset, the flag, enable and master registers read 0x00, and irq_out, irq_route, fifo_flush_pulse and dma_restart_pulse are all low.
- R2: A one-cycle pulse on ev_count_done, ev_wait_fault, ev_tc_primary or ev_tc_secondary sets flag bit 1, 5, 6 or 7 respectively, readable at address 0 from the next cycle. The bit stays set until it is cleared.
- R3: Flag bit 0 equals the value ev_xfer_level had one cycle earlier. It cannot be cleared by any clear write.
- R4: A write to address 0 (primary clear) clears flag bit 5 with data bit 3, flag bit 6 with data bit 4 and flag bit 7 with data bit 5. Data bits 2:0 have no effect, and flag bit 1 is never cleared by this register, including when the data is 0xF8.
- R5: A write to address 1 (secondary clear) with data bit 0 set clears flag bit 1. Its other data bits have no effect.
- R6: When an event pulse arrives in the same cycle as a write that clears its flag, the flag reads as set afterwards.
- R7: A primary clear write with data bit 6 set drives dma_restart_pulse high for exactly the following cycle. Data bit 7 does the same for fifo_flush_pulse. Writing 0xF8 clears all three sticky flags it covers and fires both strobes. The strobes never appear in any read.
- R8: Address 2 is the interrupt enable register: all 8 bits are written and read back unchanged, and bit n enables flag bit n.
- R9: Address 3 is the master control register. Bits 1:0 drive irq_route and bit 2 opens the interrupt. Bits 7:3 read as 0.
- R10: irq_out is high exactly when master bit 2 is set and at least one flag bit and its enable bit are both set.
- R11: Reads of address 1 and of unmapped addresses return 0x00, and flag bits 4:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ev_xfer_level | input | 1 | Data-available level (transfer ready) |
| ev_count_done | input | 1 | Count-expired event pulse |
| ev_wait_fault | input | 1 | Waited event pulse |
| ev_tc_primary | input | 1 | Primary terminal count pulse |
| ev_tc_secondary | input | 1 | Secondary terminal count pulse |
| irq_out | output | 1 | Interrupt request |
| irq_route | output | 2 | Selected interrupt line |
| fifo_flush_pulse | output | 1 | One-cycle FIFO reset strobe |
| dma_restart_pulse | output | 1 | One-cycle DMA reset strobe |

## Verification
The one-shot checks on the reset strobes assume the bus never writes in two consecutive cycles, because a second primary clear write with the same bit set would legitimately stretch the strobe. The bench's write task therefore always leaves an idle bus cycle after each write. The flag-cell properties assume events are single-cycle pulses on the sticky inputs, and the bench raises each pulse for exactly one cycle. The bench drives the collision case deliberately, with an event and its clear in the same cycle.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
   localparam int FLAG_W   = 8;
   // flag bit positions (decoded by software, kept fixed)
   localparam int F_XRDY   = 0;
   localparam int F_CEXP   = 1;
   localparam int F_WAIT   = 5;
   localparam int F_PTC    = 6;
   localparam int F_STC    = 7;
   // primary clear register bits
   localparam int C1_WAIT  = 3;
   localparam int C1_PTC   = 4;
   localparam int C1_STC   = 5;
   localparam int C1_DMA   = 6;
   localparam int C1_FIFO  = 7;
   // secondary clear register bit
   localparam int C2_CEXP  = 0;
   // master control bits
   localparam int M_OPEN   = 2;
   localparam int M_W      = 3;

   localparam logic [FLAG_W-1:0] STICKY_MASK =
      (8'd1 << F_CEXP) | (8'd1 << F_WAIT) | (8'd1 << F_PTC) | (8'd1 << F_STC);
   localparam logic [FLAG_W-1:0] LEVEL_MASK = 8'd1 << F_XRDY;

   function automatic logic [FLAG_W-1:0] clear_map(input logic pri_wr,
                                                   input logic sec_wr,
                                                   input logic [FLAG_W-1:0] d);
      logic [FLAG_W-1:0] c;
      c = '0;
      c[F_WAIT] = pri_wr & d[C1_WAIT];
      c[F_PTC]  = pri_wr & d[C1_PTC];
      c[F_STC]  = pri_wr & d[C1_STC];
      c[F_CEXP] = sec_wr & d[C2_CEXP];
      return c;
   endfunction
endpackage

// File: rtl/grp_irq_flag_cell.sv
module grp_irq_flag_cell #(
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (IS_LEVEL) begin : g_level
         logic unused_clr;
         assign unused_clr = clr_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= 1'b0;
            else        q_o <= set_i;
         end
      end else begin : g_sticky
         // event has priority over a clear in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= 1'b0;
            else        q_o <= set_i | (q_o & ~clr_i);
         end

         assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o && !clr_i) |=> q_o);
         assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
         assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !q_o);
      end
   endgenerate
endmodule

// File: rtl/grp_irq_regfile.sv
module grp_irq_regfile
   import grp_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int A_FLAGS = 0,
   parameter int A_CLR2  = 1,
   parameter int A_IEN   = 2,
   parameter int A_MCTL  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [FLAG_W-1:0] wdata_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [FLAG_W-1:0] rdata_o,
   output logic [FLAG_W-1:0] ien_o,
   output logic [M_W-1:0]    mctl_o,
   output logic [FLAG_W-1:0] clr_o,
   output logic              dma_pulse_o,
   output logic              fifo_pulse_o
);
   logic wr_pri, wr_sec, wr_ien, wr_mctl;

   assign wr_pri  = we_i && (addr_i == ADDR_W'(A_FLAGS));
   assign wr_sec  = we_i && (addr_i == ADDR_W'(A_CLR2));
   assign wr_ien  = we_i && (addr_i == ADDR_W'(A_IEN));
   assign wr_mctl = we_i && (addr_i == ADDR_W'(A_MCTL));

   assign clr_o = clear_map(wr_pri, wr_sec, wdata_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_o        <= '0;
         mctl_o       <= '0;
         dma_pulse_o  <= 1'b0;
         fifo_pulse_o <= 1'b0;
      end else begin
         if (wr_ien)  ien_o  <= wdata_i;
         if (wr_mctl) mctl_o <= wdata_i[M_W-1:0];
         dma_pulse_o  <= wr_pri & wdata_i[C1_DMA];
         fifo_pulse_o <= wr_pri & wdata_i[C1_FIFO];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(A_FLAGS))      rdata_o = flags_i;
      else if (addr_i == ADDR_W'(A_IEN))   rdata_o = ien_o;
      else if (addr_i == ADDR_W'(A_MCTL))  rdata_o = {{(FLAG_W-M_W){1'b0}}, mctl_o};
   end

   // assumes no back-to-back bus writes
   assert_dma_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_pulse_o && !we_i) |=> !dma_pulse_o);
   assert_fifo_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pulse_o && !we_i) |=> !fifo_pulse_o);
   assert_ien_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ien |=> $stable(ien_o));
endmodule

// File: rtl/grp_irq_flag_bank.sv
module grp_irq_flag_bank
   import grp_irq_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int A_FLAGS = 0,
   parameter int A_CLR2  = 1,
   parameter int A_IEN   = 2,
   parameter int A_MCTL  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              ev_xfer_level,
   input  logic              ev_count_done,
   input  logic              ev_wait_fault,
   input  logic              ev_tc_primary,
   input  logic              ev_tc_secondary,
   output logic              irq_out,
   output logic [1:0]        irq_route,
   output logic              fifo_flush_pulse,
   output logic              dma_restart_pulse
);
   localparam int NADDR = 1 << ADDR_W;

   // elaboration-time parameter checks
   if (A_FLAGS == A_CLR2 || A_FLAGS == A_IEN || A_FLAGS == A_MCTL ||
       A_CLR2 == A_IEN || A_CLR2 == A_MCTL || A_IEN == A_MCTL) begin : g_bad_map
      $error("register addresses must be distinct");
   end
   if (A_FLAGS >= NADDR || A_CLR2 >= NADDR || A_IEN >= NADDR || A_MCTL >= NADDR) begin : g_bad_range
      $error("register address exceeds ADDR_W");
   end
   if ((STICKY_MASK & LEVEL_MASK) != '0) begin : g_bad_mask
      $error("a flag cannot be both sticky and level");
   end

   logic [FLAG_W-1:0] ev_vec, clr_vec, flags, ien;
   logic [M_W-1:0]    mctl;
   logic              unused_sink;

   always_comb begin
      ev_vec         = '0;
      ev_vec[F_XRDY] = ev_xfer_level;
      ev_vec[F_CEXP] = ev_count_done;
      ev_vec[F_WAIT] = ev_wait_fault;
      ev_vec[F_PTC]  = ev_tc_primary;
      ev_vec[F_STC]  = ev_tc_secondary;
   end

   grp_irq_regfile #(
      .ADDR_W(ADDR_W), .A_FLAGS(A_FLAGS), .A_CLR2(A_CLR2),
      .A_IEN(A_IEN), .A_MCTL(A_MCTL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
      .flags_i(flags), .rdata_o(bus_rdata),
      .ien_o(ien), .mctl_o(mctl), .clr_o(clr_vec),
      .dma_pulse_o(dma_restart_pulse), .fifo_pulse_o(fifo_flush_pulse)
   );

   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      if (STICKY_MASK[i] || LEVEL_MASK[i]) begin : g_cell
         grp_irq_flag_cell #(.IS_LEVEL(LEVEL_MASK[i])) u_cell (
            .clk(clk), .rst_n(rst_n),
            .set_i(ev_vec[i]), .clr_i(clr_vec[i]), .q_o(flags[i])
         );
      end else begin : g_none
         assign flags[i] = 1'b0;
      end
   end

   assign unused_sink = ^{ev_vec, clr_vec};

   assign irq_out   = mctl[M_OPEN] & (|(flags & ien));
   assign irq_route = mctl[1:0];

   // a primary clear write never drops count-done
   assert_cexp_survives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(A_FLAGS) && flags[F_CEXP]) |=> flags[F_CEXP]);
   assert_level_not_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_xfer_level |=> flags[F_XRDY]);
   assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> (flags[4:2] == 3'b000));
endmodule

// File: tb/grp_irq_flag_bank_bench.sv
module grp_irq_flag_bank_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ev_xfer_level = 1'b0, ev_count_done = 1'b0, ev_wait_fault = 1'b0;
   logic       ev_tc_primary = 1'b0, ev_tc_secondary = 1'b0;
   logic       irq_out, fifo_flush_pulse, dma_restart_pulse;
   logic [1:0] irq_route;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   grp_irq_flag_bank u_grp_irq_flag_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_xfer_level(ev_xfer_level), .ev_count_done(ev_count_done),
      .ev_wait_fault(ev_wait_fault), .ev_tc_primary(ev_tc_primary),
      .ev_tc_secondary(ev_tc_secondary), .irq_out(irq_out),
      .irq_route(irq_route), .fifo_flush_pulse(fifo_flush_pulse),
      .dma_restart_pulse(dma_restart_pulse)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_flags(input string req, input logic [7:0] exp);
      logic [7:0] v;
      rd(4'd0, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset_R1();
      logic [7:0] v;
      check_flags("R1 flags", 8'h00);
      rd(4'd2, v); chk("R1 enable", v, 8'h00);
      rd(4'd3, v); chk("R1 master", v, 8'h00);
      chk("R1 outputs", {4'b0, irq_out, irq_route, fifo_flush_pulse | dma_restart_pulse}, 8'h00);
   endtask

   task automatic t_sticky_R2();
      @(negedge clk); ev_count_done = 1'b1;
      @(negedge clk); ev_count_done = 1'b0;
      check_flags("R2 count done", 8'h02);
      @(negedge clk); ev_wait_fault = 1'b1;
      @(negedge clk); ev_wait_fault = 1'b0;
      check_flags("R2 wait fault", 8'h22);
      @(negedge clk); ev_tc_primary = 1'b1;
      @(negedge clk); ev_tc_primary = 1'b0;
      check_flags("R2 primary tc", 8'h62);
      @(negedge clk); ev_tc_secondary = 1'b1;
      @(negedge clk); ev_tc_secondary = 1'b0;
      check_flags("R2 secondary tc", 8'hE2);
      idle(4);
      check_flags("R2 held", 8'hE2);
   endtask

   task automatic t_clear_primary_R4();
      wr(4'd0, 8'h08); check_flags("R4 clear wait", 8'hC2);
      wr(4'd0, 8'h10); check_flags("R4 clear ptc", 8'h82);
      wr(4'd0, 8'h20); check_flags("R4 clear stc", 8'h02);
      wr(4'd0, 8'h07); check_flags("R4 low bits no effect", 8'h02);
      wr(4'd0, 8'hF8); check_flags("R4 count done survives 0xF8", 8'h02);
   endtask

   task automatic t_clear_secondary_R5();
      @(negedge clk); ev_wait_fault = 1'b1;
      @(negedge clk); ev_wait_fault = 1'b0;
      wr(4'd1, 8'hFE); check_flags("R5 other bits no effect", 8'h22);
      wr(4'd1, 8'h01); check_flags("R5 clear count done", 8'h20);
      wr(4'd0, 8'hF8); check_flags("R5 all clear", 8'h00);
   endtask

   task automatic t_level_R3();
      @(negedge clk); ev_xfer_level = 1'b1;
      @(negedge clk);
      check_flags("R3 level set", 8'h01);
      wr(4'd0, 8'hFF); check_flags("R3 not clearable primary", 8'h01);
      wr(4'd1, 8'hFF); check_flags("R3 not clearable secondary", 8'h01);
      ev_xfer_level = 1'b0;
      @(negedge clk);
      check_flags("R3 level drop", 8'h00);
   endtask

   task automatic t_collision_R6();
      @(negedge clk);
      ev_wait_fault = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h08; bus_we = 1'b1;
      @(negedge clk);
      ev_wait_fault = 1'b0; bus_we = 1'b0;
      check_flags("R6 wait kept", 8'h20);
      @(negedge clk);
      ev_count_done = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h01; bus_we = 1'b1;
      @(negedge clk);
      ev_count_done = 1'b0; bus_we = 1'b0;
      check_flags("R6 count done kept", 8'h22);
      wr(4'd1, 8'h01);
      wr(4'd0, 8'h08);
      check_flags("R6 cleared after", 8'h00);
   endtask

   task automatic t_strobes_R7();
      logic [7:0] v;
      wr(4'd0, 8'h40);
      chk("R7 dma strobe", {dma_restart_pulse, fifo_flush_pulse}, 8'h02);
      rd(4'd0, v); chk("R7 strobe not readable", v, 8'h00);
      @(negedge clk);
      chk("R7 dma one cycle", {dma_restart_pulse, fifo_flush_pulse}, 8'h00);
      wr(4'd0, 8'h80);
      chk("R7 fifo strobe", {dma_restart_pulse, fifo_flush_pulse}, 8'h01);
      @(negedge clk);
      chk("R7 fifo one cycle", {dma_restart_pulse, fifo_flush_pulse}, 8'h00);
      @(negedge clk); ev_tc_primary = 1'b1; ev_tc_secondary = 1'b1; ev_wait_fault = 1'b1;
      @(negedge clk); ev_tc_primary = 1'b0; ev_tc_secondary = 1'b0; ev_wait_fault = 1'b0;
      wr(4'd0, 8'hF8);
      chk("R7 0xF8 both strobes", {dma_restart_pulse, fifo_flush_pulse}, 8'h03);
      check_flags("R7 0xF8 clears", 8'h00);
      @(negedge clk);
      chk("R7 0xF8 strobes end", {dma_restart_pulse, fifo_flush_pulse}, 8'h00);
   endtask

   task automatic t_enable_R8();
      logic [7:0] v;
      wr(4'd2, 8'hA5); rd(4'd2, v); chk("R8 enable 0xA5", v, 8'hA5);
      wr(4'd2, 8'h5A); rd(4'd2, v); chk("R8 enable 0x5A", v, 8'h5A);
   endtask

   task automatic t_master_R9();
      logic [7:0] v;
      wr(4'd3, 8'hFF); rd(4'd3, v); chk("R9 master upper zero", v, 8'h07);
      chk("R9 route 3", {6'b0, irq_route}, 8'h03);
      wr(4'd3, 8'h02); rd(4'd3, v); chk("R9 master 0x02", v, 8'h02);
      chk("R9 route 2", {6'b0, irq_route}, 8'h02);
   endtask

   task automatic t_irq_R10();
      wr(4'd2, 8'h20); wr(4'd3, 8'h04);
      chk("R10 no flag", {7'b0, irq_out}, 8'h00);
      @(negedge clk); ev_wait_fault = 1'b1;
      @(negedge clk); ev_wait_fault = 1'b0;
      chk("R10 enabled flag", {7'b0, irq_out}, 8'h01);
      wr(4'd3, 8'h03);
      chk("R10 master closed", {7'b0, irq_out}, 8'h00);
      wr(4'd3, 8'h04);
      chk("R10 master reopened", {7'b0, irq_out}, 8'h01);
      wr(4'd2, 8'h40);
      chk("R10 flag masked", {7'b0, irq_out}, 8'h00);
      wr(4'd0, 8'h08);
      wr(4'd2, 8'h01);
      @(negedge clk); ev_xfer_level = 1'b1;
      @(negedge clk);
      chk("R10 level flag", {7'b0, irq_out}, 8'h01);
      ev_xfer_level = 1'b0;
      @(negedge clk);
      chk("R10 level gone", {7'b0, irq_out}, 8'h00);
   endtask

   task automatic t_reserved_R11();
      logic [7:0] v;
      @(negedge clk);
      ev_count_done = 1'b1; ev_wait_fault = 1'b1; ev_tc_primary = 1'b1;
      ev_tc_secondary = 1'b1; ev_xfer_level = 1'b1;
      @(negedge clk);
      ev_count_done = 1'b0; ev_wait_fault = 1'b0; ev_tc_primary = 1'b0;
      ev_tc_secondary = 1'b0; ev_xfer_level = 1'b0;
      check_flags("R11 bits 4:2 zero", 8'hE3);
      rd(4'd1, v); chk("R11 secondary clear reads 0", v, 8'h00);
      rd(4'd9, v); chk("R11 unmapped reads 0", v, 8'h00);
   endtask

   initial begin : watchdog
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_R1();
      t_sticky_R2();
      t_clear_primary_R4();
      t_clear_secondary_R5();
      t_level_R3();
      t_collision_R6();
      t_strobes_R7();
      t_enable_R8();
      t_master_R9();
      t_irq_R10();
      t_reserved_R11();
      idle(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule